// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product. It spends one clock per multiplier bit, so one adder of N+1 bits serves the whole operation. A requester raises `go` together with the two operands. The block answers with a one-clock `done` pulse, and `product` holds the result in that same clock.

While it waits, the block reloads its operand registers from the inputs on every clock and clears its accumulator and counter. The operands present in the clock where `go` is high are the ones it uses. It then runs N add-and-shift steps. In each step the upper half of the accumulator takes the multiplicand when the multiplier's lowest remaining bit is 1. The sum then shifts one place down into the lower half. The clock that shows `done` is already a waiting clock. A new `go` in that clock therefore starts the next product at once, and no clock is lost between results.

Top module: `shift_mul`

## Requirements
- R1: A synchronous reset puts the block in the waiting state. While reset is high and in the first clock after it, `done_o` is 0 and `product_o` is all zeros.
- R2: In the clock where `done_o` is 1, `product_o` equals the unsigned product of `mplier_in` and `mcand_in` as they stood in the clock where `go` started the operation. Bit 0 is the least significant bit of every value.
- R3: If `go` is high in waiting clock k, `done_o` is 1 in clock k+N+1, which is after exactly N iterations. It stays 1 for that single clock only.
- R4: Whenever `done_o` is 0, `product_o` is all zeros.
- R5: Changes on `mplier_in` or `mcand_in` during the N iteration clocks do not affect the product.
- R6: `go` has no effect while iterations are running.
- R7: If `go` is high in the clock where `done_o` is 1, the next operation starts from that clock's operands. Its `done_o` follows N+1 clocks later, with no idle clock between operations.
- R8: Operand values from waiting clocks before the `go` clock have no effect on the result.
- R9: Extreme operands give exact results: zero times any value, any value times zero, all-ones times all-ones (2^2N − 2^(N+1) + 1), and a single high bit times a single high bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Starts an operation when sampled in a waiting clock |
| mplier_in | input | N | Multiplier operand, unsigned |
| mcand_in | input | N | Multiplicand operand, unsigned |
| done_o | output | 1 | One-clock pulse marking a valid product |
| product_o | output | 2N | Result in the done clock, zero otherwise |

## Verification
The assertions assume only that `go` and the operands are valid binary values at every rising edge. They assume nothing about how long `go` stays high, and they allow the operands to change in any clock, including during a run. The stimulus drives all inputs on the falling edge, so they are stable around each rising edge. It then deliberately holds `go` high through whole runs and changes the operands on every busy clock, which exercises the ignore rules. Back-to-back sequences with `go` held high for many operations cover the case where a new operation starts in the done clock.

// File: rtl/shift_mul_pkg.sv
package shift_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/shift_mul_ctrl.sv
module shift_mul_ctrl
  import shift_mul_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = (N > 2) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic load_en,
  output logic iter_en,
  output logic last_iter,
  output logic done_o
);
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_en   = (state_q == ST_IDLE);
  assign iter_en   = (state_q == ST_RUN);
  assign last_iter = iter_en && (cnt_q == LAST_CNT);
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_iter;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (go) state_q <= ST_RUN;
        end
        default: begin
          cnt_q <= cnt_q + CW'(1);
          if (last_iter) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (iter_en && !last_iter) |=> (iter_en && cnt_q == $past(cnt_q) + CW'(1))); // R3
  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cnt_q == '0)); // R8
  AST_GO_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
    (load_en && go) |=> iter_en); // R7
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    last_iter |=> (done_q && load_en)); // R7
  AST_RUN_IGNORES_GO: assert property (@(posedge clk) disable iff (rst)
    (iter_en && !last_iter) |=> iter_en); // R6
endmodule

// File: rtl/shift_mul_dp.sv
module shift_mul_dp #(
  parameter int N = 8,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          iter_en,
  input  logic          done_i,
  input  logic [N-1:0]  mplier_in,
  input  logic [N-1:0]  mcand_in,
  output logic [PW-1:0] product_o
);
  logic [N-1:0] hi_q, lo_q, mc_q, mp_q;
  logic [N:0]   step_sum;

  function automatic logic [N:0] add_step(input logic [N-1:0] acc,
                                          input logic [N-1:0] addend,
                                          input logic take);
    logic [N:0] wide_acc;
    wide_acc = {1'b0, acc};
    return take ? (wide_acc + {1'b0, addend}) : wide_acc;
  endfunction

  assign step_sum = add_step(hi_q, mc_q, mp_q[0]);

  always_ff @(posedge clk) begin
    if (load_en) begin
      hi_q <= '0;
      mc_q <= mcand_in;
      mp_q <= mplier_in;
    end else if (iter_en) begin
      hi_q <= step_sum[N:1];
      lo_q <= {step_sum[0], lo_q[N-1:1]};
      mp_q <= {1'b0, mp_q[N-1:1]};
    end
  end

  assign product_o = done_i ? {hi_q, lo_q} : '0;

  AST_MCAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    iter_en |=> (mc_q == $past(mc_q))); // R5
  AST_MPLIER_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    iter_en |=> (mp_q[N-1] == 1'b0)); // R2
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (hi_q == '0)); // R8
endmodule

// File: rtl/shift_mul.sv
module shift_mul #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [N-1:0]     mplier_in,
  input  logic [N-1:0]     mcand_in,
  output logic             done_o,
  output logic [2*N-1:0]   product_o
);
  logic load_en, iter_en, last_iter;

  initial begin
    if (N < 2) $error("shift_mul needs N >= 2");
  end

  shift_mul_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .go(go),
    .load_en(load_en), .iter_en(iter_en),
    .last_iter(last_iter), .done_o(done_o)
  );

  shift_mul_dp #(.N(N)) u_dp (
    .clk(clk), .rst(rst), .load_en(load_en), .iter_en(iter_en),
    .done_i(done_o), .mplier_in(mplier_in), .mcand_in(mcand_in),
    .product_o(product_o)
  );

  AST_PRODUCT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (product_o == '0)); // R4
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(last_iter)); // R3
endmodule

// File: tb/test_shift_mul.sv
module test_shift_mul;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [N-1:0] mp = '0;
  logic [N-1:0] mc = '0;
  logic done;
  logic [W-1:0] prod;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  int m_left = 0;
  bit m_done = 1'b0;
  logic [W-1:0] m_exp = '0;

  always #4 clk = ~clk;

  shift_mul #(.N(N)) i_shift_mul (
    .clk(clk), .rst(rst), .go(go),
    .mplier_in(mp), .mcand_in(mc),
    .done_o(done), .product_o(prod)
  );

  // Behavioural reference: counts remaining iterations, no datapath copy
  always @(posedge clk) begin
    bit nd;
    cyc++;
    if (rst) begin
      m_left = 0;
      m_done = 1'b0;
    end else begin
      nd = (m_left == 1);
      if (m_left == 0) begin
        if (go) begin
          m_left = N;
          m_exp = W'(mp) * W'(mc);
        end
      end else begin
        m_left--;
      end
      m_done = nd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (done !== m_done) begin
        errors++;
        $display("FAIL R3 [%s] cycle %0d done got %0b exp %0b", phase, cyc, done, m_done);
      end
      checks++;
      if (m_done && prod !== m_exp) begin
        errors++;
        $display("FAIL R2 [%s] cycle %0d product got %0d exp %0d", phase, cyc, prod, m_exp);
      end else if (!m_done && prod !== '0) begin
        errors++;
        $display("FAIL R4 [%s] cycle %0d product got %0d exp 0", phase, cyc, prod);
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic drive(input bit g, input logic [N-1:0] a_mp, input logic [N-1:0] a_mc);
    @(negedge clk);
    go = g;
    mp = a_mp;
    mc = a_mc;
  endtask

  task automatic one_op(input logic [N-1:0] a_mp, input logic [N-1:0] a_mc);
    drive(1'b1, a_mp, a_mc);
    for (int i = 0; i < N + 2; i++) drive(1'b0, N'($urandom), N'($urandom));
  endtask

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (done !== 1'b0 || prod !== '0) begin
        errors++;
        $display("FAIL R1 reset done got %0b exp 0, product got %0d exp 0", done, prod);
      end
    end
    rst = 1'b0;

    // R8: earlier idle operands are discarded
    phase = "R8";
    drive(1'b0, 8'd99, 8'd77);
    drive(1'b0, 8'd5, 8'd250);
    drive(1'b1, 8'd13, 8'd11);
    // R5: operands churn during the run
    phase = "R5";
    for (int i = 0; i < N; i++) drive(1'b0, N'($urandom), N'($urandom));
    phase = "R3";
    for (int i = 0; i < 3; i++) drive(1'b0, N'($urandom), N'($urandom));

    // R6: go held high through a run (done cycle restarts, also R7)
    phase = "R6";
    drive(1'b1, 8'd200, 8'd3);
    for (int i = 0; i < N; i++) drive(1'b1, N'($urandom), N'($urandom));
    for (int i = 0; i < N + 3; i++) drive(1'b0, N'($urandom), N'($urandom));

    // R7: back-to-back operations with go always high
    phase = "R7";
    for (int i = 0; i < 12 * (N + 1); i++) drive(1'b1, N'($urandom), N'($urandom));
    for (int i = 0; i < N + 3; i++) drive(1'b0, N'($urandom), N'($urandom));

    // R9: extreme operands
    phase = "R9";
    one_op(8'd0, 8'd255);
    one_op(8'd255, 8'd0);
    one_op(8'd255, 8'd255);
    one_op(8'd1, 8'd255);
    one_op(8'd128, 8'd128);
    one_op(8'd255, 8'd1);

    // R2: assorted operands with idle gaps
    phase = "R2";
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < int'($urandom_range(0, 3)); i++)
        drive(1'b0, N'($urandom), N'($urandom));
      one_op(N'($urandom), N'($urandom));
    end

    report();
    $finish;
  end
endmodule